// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for an acknowledgement or clear-to-send frame sent back in reply to a received frame. The caller presents the rate of the received frame as a single set bit in a 16-bit rate map, together with two rate tables in the same format: a preferred (basic) table and a fallback (mandatory) table. It then pulses a request strobe. One clock later the block presents the chosen rate as a one-hot word, as a 4-bit bit index, and as a flag that says no usable rate was found.

Rate map encoding: bits 0, 1, 2 and 3 stand for 1, 2, 5.5 and 11 Mb/s. Bits 8 through 15 stand for 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s. Bits 4 to 7 carry no rate. The legacy group is selected by mask 0x000F and the OFDM group by mask 0xFF00.

Rates are compared by their true speed, not by bit position. The chosen rate is the fastest entry of the preferred table that is no faster than the received rate. Only when the preferred table holds no such entry is the fallback table searched, using the same rule.

Top module: `rsp_rate_sel`

## Requirements
- R1: On a request, when the basic table holds at least one rate no faster than the received rate, `rsp_rate` is the one-hot code of the fastest such rate and `rsp_idx` is its bit position.
- R2: Bits 4 to 7 are ignored in both tables and in the received rate. They are never chosen, and a received word that also carries them is treated as the valid rate bit alone.
- R3: When the basic table has a qualifying rate, the mandatory table has no effect on the result, even if it holds a faster qualifying rate.
- R4: When the basic table has no qualifying rate, the result is the fastest rate of the mandatory table that is no faster than the received rate.
- R5: When neither table has a qualifying rate, `no_rate` is 1, `rsp_rate` is 16'h0001 and `rsp_idx` is 0. Otherwise `no_rate` is 0.
- R6: Comparison is by speed, in the order 1 < 2 < 5.5 < 6 < 9 < 11 < 12 < 18 < 24 < 36 < 48 < 54 Mb/s. So 11 Mb/s (bit 3) ranks above 9 Mb/s (bit 9), and 5.5 Mb/s (bit 2) ranks below 6 Mb/s (bit 8).
- R7: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` is high, and carries that request's result. Back-to-back requests give back-to-back results.
- R8: After reset, `rsp_valid` is 0, `rsp_rate` is 16'h0001, `rsp_idx` is 0 and `no_rate` is 0.
- R9: A received rate word with no valid rate bit, or with more than one, yields the no-rate result of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| req_valid | input | 1 | Request strobe; the inputs below are sampled while it is high |
| rx_rate | input | 16 | Rate of the received frame, one-hot in the rate map |
| basic_tbl | input | 16 | Preferred rate table |
| mand_tbl | input | 16 | Fallback rate table |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_rate | output | 16 | Chosen rate, one-hot |
| rsp_idx | output | 4 | Bit position of the chosen rate |
| no_rate | output | 1 | High when no table has a qualifying rate |

## Verification
The assertions assume that `req_valid` is low throughout reset, since the strobe check looks one cycle back. They also assume that the table and rate inputs are known whenever the strobe is high. The bench drives inputs only at falling edges, keeps the strobe low until reset is released, and always sets every data input together with the strobe. Malformed received words with zero or several rate bits are applied on purpose, because the block defines a result for them (R9), so no assertion takes a well-formed received rate for granted.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int MAP_W     = 16;
  localparam int IDX_W     = $clog2(MAP_W);
  localparam int NUM_RATES = 12;
  localparam int RANK_W    = $clog2(NUM_RATES);
  localparam logic [MAP_W-1:0] DSSS_MASK  = 16'h000F;
  localparam logic [MAP_W-1:0] OFDM_MASK  = 16'hFF00;
  localparam logic [MAP_W-1:0] VALID_MASK = DSSS_MASK | OFDM_MASK;
  localparam logic [MAP_W-1:0] SLOWEST    = 16'h0001;

  // speed rank of a bit position (0 = slowest); unused bits get rank 0
  function automatic logic [RANK_W-1:0] rank_of(input logic [IDX_W-1:0] pos);
    logic [RANK_W-1:0] r;
    case (pos)
      4'd0:  r = 4'd0;   // 1
      4'd1:  r = 4'd1;   // 2
      4'd2:  r = 4'd2;   // 5.5
      4'd8:  r = 4'd3;   // 6
      4'd9:  r = 4'd4;   // 9
      4'd3:  r = 4'd5;   // 11
      4'd10: r = 4'd6;   // 12
      4'd11, 4'd12, 4'd13, 4'd14, 4'd15: r = RANK_W'(pos - 4'd4);
      default: r = '0;
    endcase
    return r;
  endfunction

  // inverse of rank_of over the valid bits
  function automatic logic [IDX_W-1:0] bit_of_rank(input logic [RANK_W-1:0] rk);
    logic [IDX_W-1:0] p;
    case (rk)
      4'd0: p = 4'd0;
      4'd1: p = 4'd1;
      4'd2: p = 4'd2;
      4'd3: p = 4'd8;
      4'd4: p = 4'd9;
      4'd5: p = 4'd3;
      4'd6: p = 4'd10;
      4'd7, 4'd8, 4'd9, 4'd10, 4'd11: p = IDX_W'(rk + 4'd4);
      default: p = '0;
    endcase
    return p;
  endfunction

  // position of the highest set bit (0 when none)
  function automatic logic [IDX_W-1:0] enc_pos(input logic [MAP_W-1:0] v);
    logic [IDX_W-1:0] p;
    p = '0;
    for (int i = 0; i < MAP_W; i++)
      if (v[i]) p = IDX_W'(i);
    return p;
  endfunction
endpackage

// File: rtl/rrs_ceiling.sv
module rrs_ceiling
  import rrs_pkg::*;
(
  input  logic [MAP_W-1:0]  rx_rate,
  output logic [MAP_W-1:0]  allowed,
  output logic [RANK_W-1:0] rx_rank,
  output logic              rx_ok
);
  logic [MAP_W-1:0] rx_clean;
  logic [IDX_W-1:0] rx_pos;

  assign rx_clean = rx_rate & VALID_MASK;
  assign rx_ok    = ($countones(rx_clean) == 1);
  assign rx_pos   = enc_pos(rx_clean);
  assign rx_rank  = rank_of(rx_pos);

  // every valid rate whose speed does not exceed the received one
  for (genvar b = 0; b < MAP_W; b++) begin : g_allow
    assign allowed[b] = VALID_MASK[b] && rx_ok &&
                        (rank_of(IDX_W'(b)) <= rx_rank);
  end
endmodule

// File: rtl/rrs_pick.sv
module rrs_pick
  import rrs_pkg::*;
(
  input  logic [MAP_W-1:0] tbl,
  input  logic [MAP_W-1:0] allowed,
  output logic [IDX_W-1:0] pick_idx,
  output logic             found
);
  logic [MAP_W-1:0]     cand;
  logic [NUM_RATES-1:0] ranked;
  logic [RANK_W-1:0]    best;

  assign cand = tbl & allowed & VALID_MASK;

  // rearrange candidates into speed order
  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rank
    assign ranked[r] = cand[bit_of_rank(RANK_W'(r))];
  end

  // highest ranked candidate wins
  always_comb begin
    best  = '0;
    found = 1'b0;
    for (int r = 0; r < NUM_RATES; r++) begin
      if (ranked[r]) begin
        best  = RANK_W'(r);
        found = 1'b1;
      end
    end
  end

  assign pick_idx = found ? bit_of_rank(best) : '0;
endmodule

// File: rtl/rsp_rate_sel.sv
module rsp_rate_sel
  import rrs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [15:0] rx_rate,
  input  logic [15:0] basic_tbl,
  input  logic [15:0] mand_tbl,
  output logic        rsp_valid,
  output logic [15:0] rsp_rate,
  output logic [3:0]  rsp_idx,
  output logic        no_rate
);
  logic [MAP_W-1:0]  allowed_w;
  logic [RANK_W-1:0] rx_rank_w;
  logic              rx_ok_w;
  logic [IDX_W-1:0]  basic_idx_w, mand_idx_w, sel_idx_w;
  logic              basic_found_w, mand_found_w, any_found_w;

  rrs_ceiling u_ceil (
    .rx_rate (rx_rate),
    .allowed (allowed_w),
    .rx_rank (rx_rank_w),
    .rx_ok   (rx_ok_w)
  );

  rrs_pick u_basic (
    .tbl      (basic_tbl),
    .allowed  (allowed_w),
    .pick_idx (basic_idx_w),
    .found    (basic_found_w)
  );

  rrs_pick u_mand (
    .tbl      (mand_tbl),
    .allowed  (allowed_w),
    .pick_idx (mand_idx_w),
    .found    (mand_found_w)
  );

  assign any_found_w = basic_found_w | mand_found_w;
  assign sel_idx_w   = basic_found_w ? basic_idx_w : mand_idx_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rate  <= SLOWEST;
      rsp_idx   <= '0;
      no_rate   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_idx  <= any_found_w ? sel_idx_w : '0;
        rsp_rate <= any_found_w ? (MAP_W'(1) << sel_idx_w) : SLOWEST;
        no_rate  <= !any_found_w;
      end
    end
  end

  // R1
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_rate) == 1) && rsp_rate[rsp_idx]);
  // R2
  rsp_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rate & ~VALID_MASK) == '0));
  // R6
  rsp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !no_rate) |-> (rank_of(rsp_idx) <= $past(rx_rank_w)));
  // R4
  fallback_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !basic_found_w && mand_found_w) |=>
      ((rsp_rate & $past(mand_tbl)) != '0));
  // R5
  no_rate_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && no_rate) |-> (rsp_rate == SLOWEST) && (rsp_idx == '0));
  // R9
  bad_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rx_ok_w) |=> no_rate);
  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R7
  req_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/tb_rsp_rate_sel.sv
module tb_rsp_rate_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] rx_rate = '0, basic_tbl = '0, mand_tbl = '0;
  logic        rsp_valid, no_rate;
  logic [15:0] rsp_rate;
  logic [3:0]  rsp_idx;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [15:0] rate;
    logic [3:0]  idx;
    logic        none;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rsp_rate_sel dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rx_rate(rx_rate),
    .basic_tbl(basic_tbl), .mand_tbl(mand_tbl), .rsp_valid(rsp_valid),
    .rsp_rate(rsp_rate), .rsp_idx(rsp_idx), .no_rate(no_rate)
  );

  // speed in tenths of Mb/s per bit position, 0 = no rate
  function automatic int speed(input int b);
    int t[16] = '{10, 20, 55, 110, 0, 0, 0, 0, 60, 90, 120, 180, 240, 360, 480, 540};
    return t[b];
  endfunction

  function automatic int best_in(input logic [15:0] tbl, input int lim);
    int bi = -1;
    int bs = 0;
    for (int i = 0; i < 16; i++)
      if (tbl[i] && speed(i) > 0 && speed(i) <= lim && speed(i) > bs) begin
        bs = speed(i);
        bi = i;
      end
    return bi;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] rx, input logic [15:0] b,
                      input logic [15:0] m, input string tag);
    exp_t e;
    int cnt = 0;
    int lim = 0;
    int pick;
    for (int i = 0; i < 16; i++)
      if (rx[i] && speed(i) > 0) begin
        cnt++;
        lim = speed(i);
      end
    pick = -1;
    if (cnt == 1) begin
      pick = best_in(b, lim);
      if (pick < 0) pick = best_in(m, lim);
    end
    e.none = (pick < 0);
    e.idx  = (pick < 0) ? 4'd0 : 4'(pick);
    e.rate = 16'h1 << e.idx;
    e.tag  = tag;
    @(negedge clk);
    rx_rate = rx; basic_tbl = b; mand_tbl = m; req_valid = 1'b1;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each result against the queue head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "unexpected rsp_valid", 32'(rsp_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_rate == e.rate && rsp_idx == e.idx && no_rate == e.none, e.tag,
              "rate/idx/none", {11'd0, no_rate, rsp_idx, rsp_rate},
              {11'd0, e.none, e.idx, e.rate});
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        // R8 reset state
        check(rsp_valid == 1'b0 && rsp_rate == 16'h0001 && rsp_idx == 4'd0 && no_rate == 1'b0,
              "R8", "reset state", {11'd0, no_rate, rsp_idx, rsp_rate}, 32'h0000_0001);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all rates, receive 54
        send(16'h8000, 16'hFF0F, 16'h0000, "R1");
        // R1: pick 6 below 11
        send(16'h0008, 16'h0503, 16'h0000, "R1");
        // R6: 11 beats 9 when receiving 12
        send(16'h0400, 16'h0208, 16'h0000, "R6");
        // R6: receive 9 -> 9
        send(16'h0200, 16'h0208, 16'h0000, "R6");
        // R6: 5.5 below 6
        send(16'h0100, 16'h0204, 16'h0000, "R6");
        idle();
        @(negedge clk);
        // R7: nothing after idle
        check(rsp_valid == 1'b0, "R7", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        // R4 fallback
        send(16'h0002, 16'h0F00, 16'h0003, "R4");
        // R3 basic wins over faster mandatory
        send(16'h0002, 16'h0001, 16'h0002, "R3");
        // R5 nothing qualifies
        send(16'h0001, 16'h0F00, 16'h0100, "R5");
        // R2 unused bits in tables
        send(16'h8000, 16'h00F0, 16'h00F0, "R2");
        // R2 unused bits on received word
        send(16'h0042, 16'hFFFF, 16'h0000, "R2");
        // R9 malformed received words
        send(16'h0000, 16'hFFFF, 16'hFFFF, "R9");
        send(16'h0003, 16'hFFFF, 16'hFFFF, "R9");
        send(16'h00F0, 16'hFFFF, 16'hFFFF, "R9");
        idle();
        // R7 spaced requests
        send(16'h2000, 16'h1000, 16'h0000, "R7");
        idle();
        idle();
        // mixed patterns
        for (int k = 0; k < 40; k++) begin
          logic [15:0] rx;
          rx = 16'h1 << ($urandom % 16);
          send(rx, 16'($urandom), 16'($urandom), "R1");
        end
        idle();
        idle();
        idle();
        check(sb.size() == 0, "R7", "results outstanding", 32'(sb.size()), 32'd0);
      end
      begin
        repeat (20000) @(negedge clk);
        check(1'b0, "R7", "watchdog expired", 32'd1, 32'd0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule